// File: doc/BRIEF.md
# Control-Word Register Block-Command Target

This block is the target end of a block-command protocol that reaches a small byte-addressed file of control words. It sits behind an I2C target front end that has already done the bit-level work. It receives whole bytes from that front end, together with one-cycle markers for start, repeated start and stop. From each frame it decodes a command byte, a count byte, a reserved byte, a device/function byte and a 16-bit address. It then either writes 1, 2 or 4 bytes into the register file, or latches a 32-bit read response.

When the host reads the bus, the block hands out the prepared response one byte per read strobe. The response is a count of five, a status byte, and four data bytes with the highest address first. A read transaction is a full command frame followed by a short transfer. That short transfer repeats only the command byte and then switches to reading through a repeated start.

The register file holds a parameterised number of defined bytes, padded to a power-of-two depth. The lowest bytes are read-only identification values, set by a parameter.

Top module: `cwreg_block_target`

## Requirements
- R1: After reset the response reads 0x05, status 0x01 and four zero data bytes. The read-only bytes hold ID_VALUE, with byte i at ID_VALUE[8i+7:8i], and every other register reads zero.
- R2: The command byte is decoded as follows. Bits 7 and 6 (begin and end) must both be set, or the frame aborts. Bits 3:2 give the access: 00 is a 4-byte read, 01 a 1-byte write, 10 a 2-byte write and 11 a 4-byte write. When bit 4 is set, one extra trailing byte follows the count and is ignored.
- R3: The count byte must equal 4 plus the write size (4 for a read). The frame must also carry exactly 2 + count bytes, plus one when bit 4 is set. Otherwise the frame aborts and no register changes.
- R4: A write of N bytes targets the group that starts at the address with its low log2(N) bits cleared. The first data byte goes to the highest address of that group.
- R5: A write aborts and changes nothing if any byte it touches lies in the read-only range (addresses below RO_BYTES) or at or above DEFINED_BYTES.
- R6: A read ignores the two lowest address bits and returns the aligned 4-byte group, highest address first. Padding addresses read as zero.
- R7: Each start or repeated start restarts the response at its first byte, which is always 0x05. Each read strobe advances the response by one byte.
- R8: The status is set at the end of every frame longer than the command byte: 0x01 on success, 0x10 on abort. A write leaves the response data bytes unchanged. A transfer holding only the command byte changes nothing.
- R9: Response bytes requested beyond the sixth read as 0xFF.
- R10: A non-zero address high byte, or an address low byte of DEPTH or more, aborts the frame. A read that aborts this way returns zero data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse for a start or repeated start |
| frame_stop | input | 1 | One-cycle pulse for a stop |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | The bus has taken tx_byte; advance to the next response byte |
| tx_byte | output | 8 | Current response byte |

## Verification
The bench writes groups and reads them back at both aligned and unaligned addresses. A design that reversed the byte order, or failed to mask the low address bits, would return swapped or shifted data. Writes that touch identification bytes or the padding byte must leave memory intact and report abort. A design that wrote part of the group would corrupt neighbouring bytes. Frames with a wrong count, a missing begin bit, too few data bytes or a bad address high byte must abort. A frame that carries a trailing error-code byte must still succeed, so a design that counted that byte as data would fail it. Response restart, 0xFF padding, and status persistence across command-only transfers are also checked.

// File: rtl/cwreg_block_target.sv
module cwreg_block_target #(
  parameter int DEPTH         = 32,
  parameter int DEFINED_BYTES = 31,
  parameter int RO_BYTES      = 8,
  parameter logic [8*RO_BYTES-1:0] ID_VALUE = 64'h0807_0605_0403_0201
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       frame_stop,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rd_req,
  output logic [7:0] tx_byte
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [7:0] ST_OK    = 8'h01;
  localparam logic [7:0] ST_ABORT = 8'h10;

  logic [7:0]  mem [DEPTH];
  logic [3:0]  bcnt;
  logic        c_begin, c_end, c_pec;
  logic [1:0]  c_sz;
  logic [7:0]  cnt, ahi, alo;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [7:0]  status;
  logic [2:0]  rptr;

  logic        frame_end, eval;
  logic [2:0]  wn;
  logic [7:0]  base;
  logic [8:0]  want_total, data_lim, last_addr;
  logic        frame_ok, rd_ok, wr_ok;
  logic [AW-1:0] rb;

  assign frame_end  = frame_start | frame_stop;
  assign eval       = frame_end && (bcnt > 4'd1);
  assign wn         = (c_sz == 2'd1) ? 3'd1 : (c_sz == 2'd2) ? 3'd2 : (c_sz == 2'd3) ? 3'd4 : 3'd0;
  assign base       = {alo[7:2], alo[1] & (c_sz != 2'd3), alo[0] & (c_sz == 2'd1)};
  assign want_total = 9'd2 + {1'b0, cnt} + {8'd0, c_pec};
  assign data_lim   = 9'd2 + {1'b0, cnt};
  assign last_addr  = {1'b0, base} + {6'd0, wn} - 9'd1;
  assign frame_ok   = c_begin && c_end && (cnt == 8'd4 + {5'd0, wn}) &&
                      ({5'd0, bcnt} == want_total) && (ahi == 8'd0) &&
                      ({1'b0, alo} < 9'(DEPTH));
  assign rd_ok      = frame_ok && (c_sz == 2'd0);
  assign wr_ok      = frame_ok && (c_sz != 2'd0) && ({1'b0, base} >= 9'(RO_BYTES)) &&
                      (last_addr <= 9'(DEFINED_BYTES - 1));
  assign rb         = {alo[AW-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt    <= '0;
      c_begin <= 1'b0;
      c_end   <= 1'b0;
      c_pec   <= 1'b0;
      c_sz    <= '0;
      cnt     <= '0;
      ahi     <= '0;
      alo     <= '0;
      wdata   <= '0;
    end else if (frame_end) begin
      bcnt <= '0;
    end else if (rx_valid) begin
      if (bcnt != 4'hF) bcnt <= bcnt + 4'd1;
      case (bcnt)
        4'd0: begin
          c_begin <= rx_byte[7];
          c_end   <= rx_byte[6];
          c_pec   <= rx_byte[4];
          c_sz    <= rx_byte[3:2];
        end
        4'd1: cnt <= rx_byte;
        4'd4: ahi <= rx_byte;
        4'd5: alo <= rx_byte;
        default: ;
      endcase
      if (bcnt >= 4'd6 && {5'd0, bcnt} < data_lim)
        wdata <= {wdata[23:0], rx_byte};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i < RO_BYTES) ? ID_VALUE[8*(i % RO_BYTES) +: 8] : 8'h00;
      status <= ST_OK;
      rdata  <= '0;
    end else if (eval) begin
      if (c_sz == 2'd0) begin
        status <= rd_ok ? ST_OK : ST_ABORT;
        rdata  <= rd_ok ? {mem[rb + AW'(3)], mem[rb + AW'(2)], mem[rb + AW'(1)], mem[rb]} : 32'd0;
      end else begin
        status <= wr_ok ? ST_OK : ST_ABORT;
        if (wr_ok)
          for (int k = 0; k < 4; k++)
            if (k < int'(wn)) mem[base[AW-1:0] + AW'(k)] <= wdata[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        rptr <= '0;
    else if (frame_start)              rptr <= '0;
    else if (rd_req && rptr != 3'd6)   rptr <= rptr + 3'd1;
  end

  always_comb begin
    case (rptr)
      3'd0:    tx_byte = 8'h05;
      3'd1:    tx_byte = status;
      3'd2:    tx_byte = rdata[31:24];
      3'd3:    tx_byte = rdata[23:16];
      3'd4:    tx_byte = rdata[15:8];
      3'd5:    tx_byte = rdata[7:0];
      default: tx_byte = 8'hFF;
    endcase
  end
endmodule

// File: rtl/cwreg_block_target_chk.sv
module cwreg_block_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       frame_stop,
  input logic       rd_req,
  input logic [7:0] tx_byte,
  input logic [2:0] rptr,
  input logic [7:0] status
);
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (tx_byte == 8'h05));

  a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !frame_start && rptr < 3'd6) |=> (rptr == $past(rptr) + 3'd1));

  a_r8_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr == 3'd1) |-> (tx_byte == 8'h01 || tx_byte == 8'h10));

  a_r8_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !frame_stop) |=> $stable(status));

  a_r9_tail_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr == 3'd6) |-> (tx_byte == 8'hFF));

  a_r9_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rptr <= 3'd6);
endmodule

bind cwreg_block_target cwreg_block_target_chk u_chk (.*);

// File: tb/cwreg_block_target_bench.sv
module cwreg_block_target_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 1'b0, frame_stop = 1'b0, rx_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] tx_byte;
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cwreg_block_target u_cwreg_block_target (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_stop(frame_stop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_req(rd_req), .tx_byte(tx_byte));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [55:0] got, input logic [55:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse_start();
    frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic pulse_stop();
    frame_stop = 1'b1; @(negedge clk); frame_stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    rx_byte = b; rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic frame(input logic [7:0] c, input logic [7:0] cnt, input logic [7:0] ah,
                       input logic [7:0] al, input logic [31:0] d, input int nd, input bit pec);
    pulse_start();
    send(c); send(cnt); send(8'h00); send(8'h00); send(ah); send(al);
    for (int i = 0; i < nd; i++) send(d[8*(nd-1-i) +: 8]);
    if (pec) send(8'h5C);
    pulse_stop();
  endtask

  task automatic get_resp(output logic [55:0] r);
    pulse_start();
    send(8'hC2);
    pulse_start();
    for (int i = 0; i < 7; i++) begin
      r[8*(6-i) +: 8] = tx_byte;
      rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    end
    pulse_stop();
  endtask

  task automatic read_grp(input logic [7:0] ah, input logic [7:0] al, output logic [55:0] r);
    frame(8'hC2, 8'd4, ah, al, 32'd0, 0, 1'b0);
    get_resp(r);
  endtask

  task automatic t_reset();
    logic [55:0] r;
    get_resp(r);
    chk("R1 R7 R9 reset response", r, 56'h05_01_00000000_FF);
    read_grp(8'h00, 8'h00, r);
    chk("R1 R6 id group 0", r, 56'h05_01_04030201_FF);
    read_grp(8'h00, 8'h04, r);
    chk("R1 id group 4", r, 56'h05_01_08070605_FF);
    read_grp(8'h00, 8'h10, r);
    chk("R1 writable reset zero", r, 56'h05_01_00000000_FF);
  endtask

  task automatic t_writes();
    logic [55:0] r;
    frame(8'hCE, 8'd8, 8'h00, 8'h08, 32'hAABBCCDD, 4, 1'b0);
    read_grp(8'h00, 8'h08, r);
    chk("R4 dword msb first", r, 56'h05_01_AABBCCDD_FF);
    read_grp(8'h00, 8'h0A, r);
    chk("R6 unaligned read", r, 56'h05_01_AABBCCDD_FF);
    frame(8'hCA, 8'd6, 8'h00, 8'h0D, 32'h00001122, 2, 1'b0);
    read_grp(8'h00, 8'h0C, r);
    chk("R4 word aligned", r, 56'h05_01_00001122_FF);
    frame(8'hC6, 8'd5, 8'h00, 8'h0E, 32'h0000005A, 1, 1'b0);
    read_grp(8'h00, 8'h0F, r);
    chk("R4 byte write", r, 56'h05_01_005A1122_FF);
  endtask

  task automatic t_protect();
    logic [55:0] r;
    frame(8'hC6, 8'd5, 8'h00, 8'h03, 32'h000000EE, 1, 1'b0);
    get_resp(r);
    chk("R5 R8 ro write abort", r, 56'h05_10_005A1122_FF);
    get_resp(r);
    chk("R8 cmd-only keeps status", r, 56'h05_10_005A1122_FF);
    read_grp(8'h00, 8'h00, r);
    chk("R5 id intact", r, 56'h05_01_04030201_FF);
    frame(8'hCE, 8'd8, 8'h00, 8'h1C, 32'h11223344, 4, 1'b0);
    get_resp(r);
    chk("R5 pad write abort", r, 56'h05_10_04030201_FF);
    read_grp(8'h00, 8'h1D, r);
    chk("R5 R6 pad group", r, 56'h05_01_00000000_FF);
  endtask

  task automatic t_frames();
    logic [55:0] r;
    frame(8'hCE, 8'd5, 8'h00, 8'h08, 32'h01020304, 4, 1'b0);
    get_resp(r);
    chk("R3 count mismatch abort", r[47:40], 8'h10);
    frame(8'h4E, 8'd8, 8'h00, 8'h08, 32'h01020304, 4, 1'b0);
    get_resp(r);
    chk("R2 missing begin abort", r[47:40], 8'h10);
    frame(8'hCE, 8'd8, 8'h00, 8'h08, 32'h00000102, 2, 1'b0);
    get_resp(r);
    chk("R3 short frame abort", r[47:40], 8'h10);
    read_grp(8'h00, 8'h08, r);
    chk("R3 regs unchanged", r, 56'h05_01_AABBCCDD_FF);
    frame(8'hD6, 8'd5, 8'h00, 8'h14, 32'h00000077, 1, 1'b1);
    read_grp(8'h00, 8'h14, r);
    chk("R2 pec byte excluded", r, 56'h05_01_00000077_FF);
    read_grp(8'h01, 8'h08, r);
    chk("R10 high addr abort", r, 56'h05_10_00000000_FF);
    read_grp(8'h00, 8'h40, r);
    chk("R10 low addr range", r, 56'h05_10_00000000_FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_writes();
    t_protect();
    t_frames();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule